// File: doc/BRIEF.md
# Ethernet Header Wire-Order Bit Serializer

This block takes a parsed Ethernet header and sends it out one bit at a time, in the order the bits travel on the wire. The header has three fields: a six-byte destination address, a six-byte source address and a 16-bit protocol type. A single-cycle start pulse captures all three fields into the block. The block then presents one bit per accepted cycle and pauses whenever the downstream ready signal is low.

The wire order uses two different conventions. Bytes follow field order. The two address fields are byte strings, so array element 0 goes first. The type field is an integer and goes most significant byte first. Inside every byte the bits go least significant bit first. As a result, the first bit on the wire is the group (multicast) flag, which is bit 0 of destination element 0.

A marker output flags the first header bit. A one-cycle done pulse follows the last accepted bit, and the block then returns to idle.

Top module: `hdr_bit_serializer`

## Requirements
- R1: One header is exactly 112 accepted bits: 48 bits of destination address, then 48 bits of source address, then 16 bits of type.
- R2: Each address port is an array of six bytes, with element k in bits [8k+7:8k]. Element 0 goes first and element 5 goes last.
- R3: The type field goes most significant byte first, so bits [15:8] come before bits [7:0]. A type of 0x0806 sends 0x08 and then 0x06.
- R4: Inside every byte, bit 0 goes first and bit 7 goes last. The first bit of a header is therefore bit 0 of destination element 0.
- R5: A bit counts as accepted at a clock edge where `bit_valid` and `ready_in` are both high. While `ready_in` is low, `bit_valid` stays high and `ser_bit` holds its value.
- R6: `done` is high for exactly the one cycle after the last bit is accepted. In that same cycle `bit_valid` is already low, and the block is idle.
- R7: All header inputs are captured at the start pulse. Changing them afterwards has no effect on the header being sent.
- R8: A start pulse that arrives while `bit_valid` is high is ignored, and the header being sent continues unchanged.
- R9: `sof` is high only while `bit_valid` is high and the first bit of a header is on `ser_bit`.
- R10: A synchronous active-high reset clears `bit_valid`, `done` and `sof`. The next start then begins again at the first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle pulse that captures the header fields and begins sending |
| ready_in | input | 1 | Downstream accepts the presented bit at this edge |
| dst_bytes | input | 6x8 | Destination address, element 0 sent first |
| src_bytes | input | 6x8 | Source address, element 0 sent first |
| type_val | input | 16 | Protocol type value |
| ser_bit | output | 1 | Current wire bit |
| bit_valid | output | 1 | `ser_bit` holds a header bit |
| sof | output | 1 | First bit of the header is presented |
| done | output | 1 | One-cycle pulse after the last bit is accepted |

## Verification
The bench sends headers built from fixed and pseudo-random fields under three downstream ready patterns. It compares every accepted bit with a position computed independently from the byte and bit order rules. An address sent in reversed element order, or a type sent with its bytes swapped, shows up as a mismatch at a known bit position. A design that sends bits MSB first fails at the very first bit, the group flag.

Stalls check that a design which advances without ready, or changes the held bit, is caught at the following sample. The bench also changes the inputs and pulses start in the middle of a frame; a design that restarts or re-captures there puts wrong bits on the wire and raises `sof` late. A reset in the middle of a frame must drop `bit_valid` and bring the next header back to the group flag. A done pulse that is late, early or two cycles long is also caught.

// File: rtl/hdr_ser_pkg.sv
package hdr_ser_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned TYPE_BYTES = 2;

  // Number of header bytes for a given address and type size.
  function automatic int unsigned hdr_bytes(input int unsigned a, input int unsigned t);
    return 2 * a + t;
  endfunction

  // Wire slot of type byte j: the most significant byte goes first.
  function automatic int unsigned type_lane(input int unsigned j, input int unsigned t);
    return t - 1 - j;
  endfunction
endpackage

// File: rtl/hdr_ser_capture.sv
module hdr_ser_capture
  import hdr_ser_pkg::*;
#(
  parameter int unsigned A_BYTES = ADDR_BYTES,
  parameter int unsigned T_BYTES = TYPE_BYTES,
  parameter int unsigned W       = BYTE_W,
  localparam int unsigned NB     = 2 * A_BYTES + T_BYTES
) (
  input  logic                           clk,
  input  logic                           load,
  input  logic [A_BYTES-1:0][W-1:0]      dst,
  input  logic [A_BYTES-1:0][W-1:0]      src,
  input  logic [T_BYTES*W-1:0]           typ,
  output logic [NB-1:0][W-1:0]           frame_q
);
  // Byte k of this array is wire byte k.
  logic [NB-1:0][W-1:0] frame_d;

  for (genvar k = 0; k < A_BYTES; k++) begin : g_addr
    assign frame_d[k]           = dst[k];
    assign frame_d[A_BYTES + k] = src[k];
  end

  for (genvar j = 0; j < T_BYTES; j++) begin : g_type
    assign frame_d[2*A_BYTES + j] = typ[type_lane(j, T_BYTES)*W +: W];
  end

  always_ff @(posedge clk) begin
    if (load) frame_q <= frame_d;
  end
endmodule

// File: rtl/hdr_ser_sequencer.sv
module hdr_ser_sequencer #(
  parameter int unsigned NB = 14,
  parameter int unsigned W  = 8,
  localparam int unsigned BYW = $clog2(NB),
  localparam int unsigned BIW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           ready_in,
  output logic           valid_q,
  output logic           done_q,
  output logic [BYW-1:0] byte_idx,
  output logic [BIW-1:0] bit_idx,
  output logic           load_evt,
  output logic           accept_evt,
  output logic           last_evt
);
  localparam logic [BYW-1:0] LAST_BYTE = BYW'(NB - 1);
  localparam logic [BIW-1:0] LAST_BIT  = BIW'(W - 1);

  function automatic logic at_end(input logic [BYW-1:0] by, input logic [BIW-1:0] bi);
    return (by == LAST_BYTE) && (bi == LAST_BIT);
  endfunction

  assign load_evt   = start && !valid_q;
  assign accept_evt = valid_q && ready_in;
  assign last_evt   = accept_evt && at_end(byte_idx, bit_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else begin
      done_q <= last_evt;
      if (load_evt) begin
        valid_q  <= 1'b1;
        byte_idx <= '0;
        bit_idx  <= '0;
      end else if (accept_evt) begin
        if (bit_idx == LAST_BIT) begin
          bit_idx <= '0;
          if (byte_idx == LAST_BYTE) begin
            byte_idx <= '0;
            valid_q  <= 1'b0;
          end else begin
            byte_idx <= byte_idx + 1'b1;
          end
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdr_ser_bitpick.sv
module hdr_ser_bitpick #(
  parameter int unsigned NB = 14,
  parameter int unsigned W  = 8,
  localparam int unsigned BYW = $clog2(NB),
  localparam int unsigned BIW = $clog2(W)
) (
  input  logic [NB-1:0][W-1:0] frame,
  input  logic [BYW-1:0]       byte_idx,
  input  logic [BIW-1:0]       bit_idx,
  input  logic                 valid,
  output logic                 ser_bit,
  output logic                 first
);
  // Bit 0 of each byte goes first: the bit index picks the bit directly.
  always_comb begin
    ser_bit = valid ? frame[byte_idx][bit_idx] : 1'b0;
    first   = valid && (byte_idx == '0) && (bit_idx == '0);
  end
endmodule

// File: rtl/hdr_bit_serializer.sv
module hdr_bit_serializer
  import hdr_ser_pkg::*;
#(
  parameter int unsigned A_BYTES = ADDR_BYTES,
  parameter int unsigned T_BYTES = TYPE_BYTES,
  parameter int unsigned W       = BYTE_W,
  localparam int unsigned NB     = 2 * A_BYTES + T_BYTES,
  localparam int unsigned BYW    = $clog2(NB),
  localparam int unsigned BIW    = $clog2(W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      ready_in,
  input  logic [A_BYTES-1:0][W-1:0] dst_bytes,
  input  logic [A_BYTES-1:0][W-1:0] src_bytes,
  input  logic [T_BYTES*W-1:0]      type_val,
  output logic                      ser_bit,
  output logic                      bit_valid,
  output logic                      sof,
  output logic                      done
);
  logic [NB-1:0][W-1:0] frame_q;
  logic [BYW-1:0]       byte_idx;
  logic [BIW-1:0]       bit_idx;
  logic                 load_evt;
  logic                 accept_evt;
  logic                 last_evt;

  hdr_ser_capture #(.A_BYTES(A_BYTES), .T_BYTES(T_BYTES), .W(W)) u_cap (
    .clk     (clk),
    .load    (load_evt),
    .dst     (dst_bytes),
    .src     (src_bytes),
    .typ     (type_val),
    .frame_q (frame_q)
  );

  hdr_ser_sequencer #(.NB(NB), .W(W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ready_in   (ready_in),
    .valid_q    (bit_valid),
    .done_q     (done),
    .byte_idx   (byte_idx),
    .bit_idx    (bit_idx),
    .load_evt   (load_evt),
    .accept_evt (accept_evt),
    .last_evt   (last_evt)
  );

  hdr_ser_bitpick #(.NB(NB), .W(W)) u_pick (
    .frame    (frame_q),
    .byte_idx (byte_idx),
    .bit_idx  (bit_idx),
    .valid    (bit_valid),
    .ser_bit  (ser_bit),
    .first    (sof)
  );
endmodule

// File: rtl/hdr_ser_checker.sv
module hdr_ser_checker #(
  parameter int unsigned HDR_BITS = 112,
  localparam int unsigned CW = $clog2(HDR_BITS + 1)
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ready_in,
  input logic ser_bit,
  input logic bit_valid,
  input logic sof,
  input logic done,
  input logic load_evt,
  input logic accept_evt,
  input logic last_evt
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load_evt) cnt <= '0;
    else if (accept_evt) cnt <= cnt + 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!bit_valid && !done)); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !ready_in) |=> (bit_valid && $stable(ser_bit))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_evt |=> (done && !bit_valid)); // R6
  AST_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == CW'(HDR_BITS))); // R1
  AST_SOF_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    sof |-> (bit_valid && cnt == '0)); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && bit_valid && cnt != '0) |=> !sof); // R8
endmodule

bind hdr_bit_serializer hdr_ser_checker #(.HDR_BITS(NB * W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .ready_in   (ready_in),
  .ser_bit    (ser_bit),
  .bit_valid  (bit_valid),
  .sof        (sof),
  .done       (done),
  .load_evt   (load_evt),
  .accept_evt (accept_evt),
  .last_evt   (last_evt)
);

// File: tb/hdr_bit_serializer_test.sv
`timescale 1ns/1ps
module hdr_bit_serializer_test;
  localparam int NBITS = 112;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst, start, ready_in;
  logic [5:0][7:0] dst_bytes, src_bytes;
  logic [15:0]     type_val;
  logic            ser_bit, bit_valid, sof, done;

  int vectors = 0;
  int fails   = 0;
  logic [15:0] lfsr = 16'hACE1;
  int wd = 0;

  hdr_bit_serializer uut (
    .clk(clk), .rst(rst), .start(start), .ready_in(ready_in),
    .dst_bytes(dst_bytes), .src_bytes(src_bytes), .type_val(type_val),
    .ser_bit(ser_bit), .bit_valid(bit_valid), .sof(sof), .done(done)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [15:0] step(input logic [15:0] v);
    return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
  endfunction

  // Wire byte n: address elements in array order, then type MSB first (R2, R3).
  function automatic int wire_byte(input logic [5:0][7:0] d, input logic [5:0][7:0] s,
                                   input logic [15:0] t, input int n);
    if (n < 6)  return int'(d[n]);
    if (n < 12) return int'(s[n-6]);
    if (n == 12) return int'(t) / 256;
    return int'(t) % 256;
  endfunction

  // Bit n on the wire: LSB of each byte first (R4).
  function automatic int wire_bit(input logic [5:0][7:0] d, input logic [5:0][7:0] s,
                                  input logic [15:0] t, input int n);
    return (wire_byte(d, s, t, n / 8) >> (n % 8)) & 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [5:0][7:0] d, input logic [5:0][7:0] s,
                           input logic [15:0] t, input int mode, input int glitch);
    int n = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic prev_bit = 0;
    bit rdy;
    @(negedge clk);
    dst_bytes = d; src_bytes = s; type_val = t;
    start = 1'b1; ready_in = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (n < NBITS && cyc < 5000) begin
      if (cyc > 0) @(negedge clk);
      if (cyc == 1) begin  // R7: scramble inputs after capture
        dst_bytes = ~d; src_bytes = d; type_val = ~t;
      end
      if (glitch > 1 && cyc == glitch) start = 1'b1;      // R8
      else if (glitch > 1 && cyc == glitch + 1) start = 1'b0;
      if (prev_stall)
        check(bit_valid && ser_bit == prev_bit, "R5", "held bit", int'(ser_bit), int'(prev_bit));
      if (!bit_valid) begin
        check(0, "R6", "valid dropped early at bit", n, NBITS);
        break;
      end
      check(sof == (n == 0), "R9", "sof marker", int'(sof), int'(n == 0));
      check(!done, "R6", "done while sending", int'(done), 0);
      case (mode)
        0: rdy = 1'b1;
        1: rdy = lfsr[0] | lfsr[1];
        default: rdy = cyc[0];
      endcase
      lfsr = step(lfsr);
      ready_in = rdy;
      if (rdy) begin
        check(int'(ser_bit) == wire_bit(d, s, t, n), (n < 96) ? "R2 R4" : "R3 R4",
              $sformatf("wire bit %0d", n), int'(ser_bit), wire_bit(d, s, t, n));
        n++;
      end
      prev_stall = !rdy;
      prev_bit = ser_bit;
      cyc++;
    end
    start = 1'b0;
    @(negedge clk);
    ready_in = 1'b0;
    check(done && !bit_valid, "R6", "done after last bit", int'({done, bit_valid}), 2);
    @(negedge clk);
    check(!done && !bit_valid, "R6", "single done then idle", int'({done, bit_valid}), 0);
  endtask

  initial begin
    logic [5:0][7:0] d, s;
    logic [15:0] t;
    rst = 1'b1; start = 1'b0; ready_in = 1'b0;
    dst_bytes = '0; src_bytes = '0; type_val = '0;
    repeat (3) @(negedge clk);
    check(!bit_valid && !done && !sof, "R10", "reset state",
          int'({bit_valid, done, sof}), 0);
    rst = 1'b0;

    // R1 R3: named addresses and type 0x0806
    d = {8'hbc, 8'h9a, 8'h78, 8'h56, 8'h34, 8'h12};
    s = {8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01};
    run_frame(d, s, 16'h0806, 0, 0);
    // R4: group flag set in element 0 only
    run_frame({40'h0, 8'h01}, '0, 16'h0001, 0, 0);
    run_frame('1, '0, 16'hFFFF, 2, 0);
    run_frame({8'h80, 40'h0}, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80}, 16'h8000, 1, 7);

    for (int mode = 0; mode < 3; mode++) begin
      for (int i = 0; i < 12; i++) begin
        for (int k = 0; k < 6; k++) begin
          lfsr = step(lfsr); d[k] = lfsr[7:0];
          lfsr = step(lfsr); s[k] = lfsr[15:8];
        end
        lfsr = step(lfsr); t = lfsr;
        run_frame(d, s, t, mode, (i % 3 == 0) ? 4 + 3 * i : 0);
      end
    end

    // R10: reset in the middle of a header
    @(negedge clk);
    dst_bytes = '1; src_bytes = '1; type_val = '1; start = 1'b1; ready_in = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!bit_valid && !done && !sof, "R10", "mid-frame reset",
          int'({bit_valid, done, sof}), 0);
    rst = 1'b0; ready_in = 1'b0;
    run_frame({8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, '0, 16'h86DD, 1, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule